// File: doc/BRIEF.md
# Repeat-Loop Program Counter Sequencer

This block owns the program counter of a core that issues one instruction packet per step and has a zero-overhead repeat loop, a single instruction breakpoint and one external interrupt line. On every step strobe it works out the next PC from the branch result, the loop bounds and the repeat count. It then applies the breakpoint trap and interrupt entry, which can override that PC. Between steps, the surrounding core can load a new loop (start, end, count) or overwrite the status word. Fetch, decode and execution are not part of this block.

The status word is six bits wide. Its bits are the loop-active flag, the interrupt enable, the breakpoint enable, the debug-mode flag, the breakpoint-hit marker and the stack selector. The block keeps one saved PC and status pair for debug entry and another for interrupt entry. It also holds one pending interrupt request for a request that arrives while interrupts are masked.

Top module: `pc_seq_rpt`

## Requirements
- R1: While `rst_ni` is low, the PC is `RESET_VEC` (0x0000_1000 by default). The count, loop bounds, saved PCs, status words and pending flag are all zero.
- R2: A step with no branch, no loop-back and no trap or interrupt advances the PC by 8. The status and count are left as they were.
- R3: A step decrements the count by exactly one when the PC equals the loop end and either the count is nonzero or the loop-active flag is set. Otherwise the count is unchanged.
- R4: The PC goes back to the loop start when the loop-active flag is set, the PC equals the loop end, and the count was nonzero before this step's decrement. This holds even if the decrement takes the count to zero. Otherwise the PC falls through.
- R5: After a step at the loop end, the loop-active flag is cleared if it was set and the decremented count is zero.
- R6: A taken branch sets the PC to the branch target. This takes priority over loop-back and fall-through, and the count update of R3 still happens.
- R7: Status bit positions are: bit 0 loop-active, bit 1 interrupt enable, bit 2 breakpoint enable, bit 3 debug mode, bit 4 breakpoint hit, bit 5 stack select. Loop loads and status writes take effect only on cycles without a step, and a loop load also sets bit 0. During a step, both are ignored.
- R8: A step whose PC equals the breakpoint address, with breakpoint enable set, traps after the loop logic has run. The debug PC takes the PC the step would have produced. The debug status takes the post-loop status with bit 4 set. The status keeps only stack select plus debug mode, and the PC becomes 0xFFFF_F128.
- R9: When a request (new or pending) meets an interrupt enable that is set in the post-trap status, a step does the following. The backup PC and backup status take the post-trap PC and status, the status is cleared, the PC becomes 0xFFFF_F138, and the pending flag is cleared.
- R10: A request that meets a masked interrupt enable becomes one pending request, which is retried on every later step. Requests that arrive while one is pending are dropped, so only one interrupt entry follows.
- R11: With no step, the PC does not change. The count changes only through a loop load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | One packet completes this cycle |
| br_taken_i | input | 1 | Packet took a branch |
| br_target_i | input | AW | Branch target address |
| irq_i | input | 1 | External interrupt request, sampled on steps |
| cfg_ld_i | input | 1 | Load loop start, end and count |
| cfg_start_i | input | AW | Loop start address |
| cfg_end_i | input | AW | Loop end address |
| cfg_cnt_i | input | CW | Repeat count |
| stat_wr_i | input | 1 | Overwrite the status word |
| stat_i | input | 6 | Status write data |
| brk_addr_i | input | AW | Breakpoint address |
| pc_o | output | AW | Current PC |
| cnt_o | output | CW | Current repeat count |
| stat_o | output | 6 | Current status word |
| dpc_o | output | AW | Debug-entry saved PC |
| dstat_o | output | 6 | Debug-entry saved status |
| bpc_o | output | AW | Interrupt-entry saved PC |
| bstat_o | output | 6 | Interrupt-entry saved status |
| irq_pend_o | output | 1 | A masked interrupt is pending |

## Verification
Several properties are checked by assertions on every cycle. The PC and count hold while no step occurs. A step never moves the count by more than one. A branch lands on its target when no trap applies, and a breakpoint hit always lands on the debug vector. An enabled request always lands on the interrupt vector with a cleared status, and a masked request always leaves a pending flag. Other behaviour can only be shown by the bench's scenarios, because the loop bounds and saved registers are not visible at the ports. This covers the number of loop iterations a count produces and the loop-back taken on the final decrement. It also covers the values captured into the saved registers, configuration writes that are ignored during a step, and a second request that is dropped while one is pending.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int unsigned STAT_W = 6;

  // bit 5 .. bit 0
  typedef struct packed {
    logic stk;  // stack select
    logic bkh;  // breakpoint hit marker
    logic dbm;  // debug mode
    logic dbe;  // breakpoint enable
    logic ien;  // interrupt enable
    logic rpt;  // repeat loop active
  } stat_t;
endpackage

// File: rtl/pcs_loop.sv
module pcs_loop #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16,
  parameter logic [AW-1:0] STEP = 8
) (
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] lp_start_i,
  input  logic [AW-1:0] lp_end_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          rpt_i,
  input  logic          br_taken_i,
  input  logic [AW-1:0] br_target_i,
  output logic [CW-1:0] cnt_o,
  output logic          rpt_o,
  output logic [AW-1:0] pc_o
);
  logic at_end, cnt_nz, loop_back;
  logic [CW-1:0] cnt_dec;

  always_comb begin
    at_end    = (pc_i == lp_end_i);
    cnt_nz    = |cnt_i;  // sampled before the decrement
    cnt_dec   = (at_end && (cnt_nz || rpt_i)) ? cnt_i - 1'b1 : cnt_i;
    loop_back = rpt_i && cnt_nz && at_end;
    cnt_o     = cnt_dec;
    rpt_o     = rpt_i && !(at_end && (cnt_dec == '0));
    if (br_taken_i)     pc_o = br_target_i;
    else if (loop_back) pc_o = lp_start_i;
    else                pc_o = pc_i + STEP;
  end
endmodule

// File: rtl/pcs_trap.sv
module pcs_trap
  import pcs_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter logic [AW-1:0] DBG_VEC = 32'hFFFF_F128,
  parameter logic [AW-1:0] IRQ_VEC = 32'hFFFF_F138
) (
  input  logic [AW-1:0] cia_i,
  input  logic [AW-1:0] pc_seq_i,
  input  stat_t         stat_i,
  input  logic [AW-1:0] brk_addr_i,
  input  logic          irq_req_i,
  output logic          dbg_hit_o,
  output logic [AW-1:0] dpc_o,
  output stat_t         dstat_o,
  output logic          irq_hit_o,
  output logic [AW-1:0] bpc_o,
  output stat_t         bstat_o,
  output logic [AW-1:0] pc_o,
  output stat_t         stat_o
);
  stat_t         st_mid;
  logic [AW-1:0] pc_mid;

  always_comb begin
    dbg_hit_o   = (cia_i == brk_addr_i) && stat_i.dbe;
    dpc_o       = pc_seq_i;
    dstat_o     = stat_i;
    dstat_o.bkh = 1'b1;
    if (dbg_hit_o) begin
      st_mid     = '0;
      st_mid.stk = stat_i.stk;
      st_mid.dbm = 1'b1;
      pc_mid     = DBG_VEC;
    end else begin
      st_mid = stat_i;
      pc_mid = pc_seq_i;
    end
    // interrupt sees the post-trap status
    irq_hit_o = irq_req_i && st_mid.ien;
    bpc_o     = pc_mid;
    bstat_o   = st_mid;
    pc_o      = irq_hit_o ? IRQ_VEC : pc_mid;
    stat_o    = irq_hit_o ? stat_t'('0) : st_mid;
  end
endmodule

// File: rtl/pc_seq_rpt.sv
module pc_seq_rpt
  import pcs_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16,
  parameter logic [AW-1:0] RESET_VEC = 32'h0000_1000,
  parameter logic [AW-1:0] DBG_VEC   = 32'hFFFF_F128,
  parameter logic [AW-1:0] IRQ_VEC   = 32'hFFFF_F138
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              br_taken_i,
  input  logic [AW-1:0]     br_target_i,
  input  logic              irq_i,
  input  logic              cfg_ld_i,
  input  logic [AW-1:0]     cfg_start_i,
  input  logic [AW-1:0]     cfg_end_i,
  input  logic [CW-1:0]     cfg_cnt_i,
  input  logic              stat_wr_i,
  input  logic [STAT_W-1:0] stat_i,
  input  logic [AW-1:0]     brk_addr_i,
  output logic [AW-1:0]     pc_o,
  output logic [CW-1:0]     cnt_o,
  output logic [STAT_W-1:0] stat_o,
  output logic [AW-1:0]     dpc_o,
  output logic [STAT_W-1:0] dstat_o,
  output logic [AW-1:0]     bpc_o,
  output logic [STAT_W-1:0] bstat_o,
  output logic              irq_pend_o
);
  localparam logic [AW-1:0] PKT_BYTES = AW'(8);

  logic [AW-1:0] pc_q, start_q, end_q, dpc_q, bpc_q;
  logic [CW-1:0] cnt_q;
  stat_t         stat_q, dstat_q, bstat_q;
  logic          pend_q;

  logic [CW-1:0] cnt_nx;
  logic          rpt_nx;
  logic [AW-1:0] pc_seq;
  stat_t         stat_lp;

  logic          dbg_hit, irq_hit;
  logic [AW-1:0] dpc_nx, bpc_nx, pc_nx;
  stat_t         dstat_nx, bstat_nx, stat_nx;

  pcs_loop #(.AW(AW), .CW(CW), .STEP(PKT_BYTES)) u_loop (
    .pc_i        (pc_q),
    .lp_start_i  (start_q),
    .lp_end_i    (end_q),
    .cnt_i       (cnt_q),
    .rpt_i       (stat_q.rpt),
    .br_taken_i  (br_taken_i),
    .br_target_i (br_target_i),
    .cnt_o       (cnt_nx),
    .rpt_o       (rpt_nx),
    .pc_o        (pc_seq)
  );

  always_comb begin
    stat_lp     = stat_q;
    stat_lp.rpt = rpt_nx;
  end

  pcs_trap #(.AW(AW), .DBG_VEC(DBG_VEC), .IRQ_VEC(IRQ_VEC)) u_trap (
    .cia_i      (pc_q),
    .pc_seq_i   (pc_seq),
    .stat_i     (stat_lp),
    .brk_addr_i (brk_addr_i),
    .irq_req_i  (irq_i || pend_q),
    .dbg_hit_o  (dbg_hit),
    .dpc_o      (dpc_nx),
    .dstat_o    (dstat_nx),
    .irq_hit_o  (irq_hit),
    .bpc_o      (bpc_nx),
    .bstat_o    (bstat_nx),
    .pc_o       (pc_nx),
    .stat_o     (stat_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= RESET_VEC;
      cnt_q   <= '0;
      start_q <= '0;
      end_q   <= '0;
      stat_q  <= '0;
      dpc_q   <= '0;
      dstat_q <= '0;
      bpc_q   <= '0;
      bstat_q <= '0;
      pend_q  <= 1'b0;
    end else if (step_i) begin
      pc_q   <= pc_nx;
      cnt_q  <= cnt_nx;
      stat_q <= stat_nx;
      if (dbg_hit) begin
        dpc_q   <= dpc_nx;
        dstat_q <= dstat_nx;
      end
      if (irq_hit) begin
        bpc_q   <= bpc_nx;
        bstat_q <= bstat_nx;
        pend_q  <= 1'b0;
      end else if (irq_i) begin
        pend_q  <= 1'b1;  // later requests fold into this one
      end
    end else begin
      if (stat_wr_i) stat_q <= stat_t'(stat_i);
      if (cfg_ld_i) begin
        start_q    <= cfg_start_i;
        end_q      <= cfg_end_i;
        cnt_q      <= cfg_cnt_i;
        stat_q.rpt <= 1'b1;
      end
    end
  end

  assign pc_o       = pc_q;
  assign cnt_o      = cnt_q;
  assign stat_o     = stat_q;
  assign dpc_o      = dpc_q;
  assign dstat_o    = dstat_q;
  assign bpc_o      = bpc_q;
  assign bstat_o    = bstat_q;
  assign irq_pend_o = pend_q;
endmodule

// File: rtl/pc_seq_rpt_chk.sv
module pc_seq_rpt_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned CW = 16,
  parameter logic [AW-1:0] DBG_VEC = 32'hFFFF_F128,
  parameter logic [AW-1:0] IRQ_VEC = 32'hFFFF_F138
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          step_i,
  input logic          br_taken_i,
  input logic [AW-1:0] br_target_i,
  input logic          irq_i,
  input logic          cfg_ld_i,
  input logic [AW-1:0] brk_addr_i,
  input logic [AW-1:0] pc_o,
  input logic [CW-1:0] cnt_o,
  input logic [5:0]    stat_o,
  input logic          irq_pend_o
);
  logic brk_now;
  assign brk_now = (pc_o == brk_addr_i) && stat_o[2];

  assert_pc_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(pc_o));

  assert_cnt_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !cfg_ld_i) |=> $stable(cnt_o));

  assert_cnt_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) - 1'b1));

  assert_branch_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && br_taken_i && !brk_now && !irq_i && !irq_pend_o)
      |=> pc_o == $past(br_target_i));

  assert_brk_vector_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && brk_now) |=> (pc_o == DBG_VEC && stat_o[3] && !stat_o[1]));

  assert_irq_entry_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && (irq_i || irq_pend_o) && stat_o[1] && !brk_now)
      |=> (pc_o == IRQ_VEC && stat_o == 6'd0 && !irq_pend_o));

  assert_irq_pend_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && irq_i && !stat_o[1]) |=> irq_pend_o);
endmodule

bind pc_seq_rpt pc_seq_rpt_chk #(.AW(AW), .CW(CW), .DBG_VEC(DBG_VEC), .IRQ_VEC(IRQ_VEC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .step_i      (step_i),
  .br_taken_i  (br_taken_i),
  .br_target_i (br_target_i),
  .irq_i       (irq_i),
  .cfg_ld_i    (cfg_ld_i),
  .brk_addr_i  (brk_addr_i),
  .pc_o        (pc_o),
  .cnt_o       (cnt_o),
  .stat_o      (stat_o),
  .irq_pend_o  (irq_pend_o)
);

// File: tb/pc_seq_rpt_bench.sv
module pc_seq_rpt_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        step_i = 1'b0, br_taken_i = 1'b0, irq_i = 1'b0;
  logic [31:0] br_target_i = '0;
  logic        cfg_ld_i = 1'b0, stat_wr_i = 1'b0;
  logic [31:0] cfg_start_i = '0, cfg_end_i = '0;
  logic [15:0] cfg_cnt_i = '0;
  logic [5:0]  stat_wdata = '0;
  logic [31:0] brk_addr_i = 32'h0000_0004;
  logic [31:0] pc_o, dpc_o, bpc_o;
  logic [15:0] cnt_o;
  logic [5:0]  stat_o, dstat_o, bstat_o;
  logic        irq_pend_o;

  int n_cmp = 0, n_bad = 0;

  logic [31:0] q_pc[$];
  logic [15:0] q_cnt[$];
  logic [5:0]  q_st[$];
  logic        q_pend[$];
  string       q_tag[$];

  always #5 clk = ~clk;

  pc_seq_rpt u_pc_seq_rpt (
    .clk_i(clk), .rst_ni(rst_ni), .step_i(step_i), .br_taken_i(br_taken_i),
    .br_target_i(br_target_i), .irq_i(irq_i), .cfg_ld_i(cfg_ld_i),
    .cfg_start_i(cfg_start_i), .cfg_end_i(cfg_end_i), .cfg_cnt_i(cfg_cnt_i),
    .stat_wr_i(stat_wr_i), .stat_i(stat_wdata), .brk_addr_i(brk_addr_i),
    .pc_o(pc_o), .cnt_o(cnt_o), .stat_o(stat_o), .dpc_o(dpc_o),
    .dstat_o(dstat_o), .bpc_o(bpc_o), .bstat_o(bstat_o), .irq_pend_o(irq_pend_o)
  );

  task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one packet step, expected outputs queued for the monitor
  task automatic step_pkt(input logic br, input logic [31:0] tgt, input logic irq,
                          input logic noise, input logic [31:0] epc,
                          input logic [15:0] ecnt, input logic [5:0] est,
                          input logic epend, input string tag);
    @(negedge clk);
    step_i = 1'b1; br_taken_i = br; br_target_i = tgt; irq_i = irq;
    if (noise) begin
      cfg_ld_i = 1'b1; cfg_start_i = 32'h4000; cfg_end_i = 32'h4008;
      cfg_cnt_i = 16'h55; stat_wr_i = 1'b1; stat_wdata = 6'h3F;
    end
    q_pc.push_back(epc); q_cnt.push_back(ecnt); q_st.push_back(est);
    q_pend.push_back(epend); q_tag.push_back(tag);
    @(negedge clk);
    step_i = 1'b0; br_taken_i = 1'b0; irq_i = 1'b0; cfg_ld_i = 1'b0; stat_wr_i = 1'b0;
  endtask

  task automatic cfg_load(input logic [31:0] s, input logic [31:0] e, input logic [15:0] c);
    @(negedge clk);
    cfg_ld_i = 1'b1; cfg_start_i = s; cfg_end_i = e; cfg_cnt_i = c;
    @(negedge clk);
    cfg_ld_i = 1'b0;
  endtask

  task automatic stat_write(input logic [5:0] v);
    @(negedge clk);
    stat_wr_i = 1'b1; stat_wdata = v;
    @(negedge clk);
    stat_wr_i = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      if (q_pc.size() != 0) begin
        logic [31:0] epc;
        logic [15:0] ecnt;
        logic [5:0]  est;
        logic        epend;
        string       tag;
        #2;
        epc = q_pc.pop_front(); ecnt = q_cnt.pop_front(); est = q_st.pop_front();
        epend = q_pend.pop_front(); tag = q_tag.pop_front();
        n_cmp++;
        if (pc_o !== epc || cnt_o !== ecnt || stat_o !== est || irq_pend_o !== epend) begin
          n_bad++;
          $display("FAIL %s actual pc=%h cnt=%h st=%h pend=%b expected pc=%h cnt=%h st=%h pend=%b",
                   tag, pc_o, cnt_o, stat_o, irq_pend_o, epc, ecnt, est, epend);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check_val("R1 reset pc", pc_o, 32'h1000);
    check_val("R1 reset cnt", {16'd0, cnt_o}, 32'd0);
    check_val("R1 reset stat", {26'd0, stat_o}, 32'd0);
    rst_ni = 1'b1;

    step_pkt(0, 0, 0, 0, 32'h1008, 0, 6'h00, 0, "R2 sequential");
    step_pkt(1, 32'h2000, 0, 0, 32'h2000, 0, 6'h00, 0, "R6 branch");

    cfg_load(32'h2008, 32'h2010, 16'd2);
    check_val("R7 load cnt", {16'd0, cnt_o}, 32'd2);
    check_val("R7 load sets loop flag", {26'd0, stat_o}, 32'h01);
    check_val("R11 pc held", pc_o, 32'h2000);

    step_pkt(0, 0, 0, 0, 32'h2008, 2, 6'h01, 0, "R3 no decrement off end");
    step_pkt(0, 0, 0, 0, 32'h2010, 2, 6'h01, 0, "R2 in body");
    step_pkt(0, 0, 0, 0, 32'h2008, 1, 6'h01, 0, "R4 loop back");
    step_pkt(0, 0, 0, 0, 32'h2010, 1, 6'h01, 0, "R2 in body");
    step_pkt(0, 0, 0, 0, 32'h2008, 0, 6'h00, 0, "R5 R4 last loop back");
    step_pkt(0, 0, 0, 0, 32'h2010, 0, 6'h00, 0, "R2 last pass");
    step_pkt(0, 0, 0, 0, 32'h2018, 0, 6'h00, 0, "R4 fall through");

    cfg_load(32'h2000, 32'h2018, 16'd1);
    step_pkt(1, 32'h4000, 0, 0, 32'h4000, 0, 6'h00, 0, "R6 branch at loop end");
    step_pkt(0, 0, 0, 1, 32'h4008, 0, 6'h00, 0, "R7 writes ignored in step");
    step_pkt(0, 0, 0, 0, 32'h4010, 0, 6'h00, 0, "R7 no loop loaded");

    brk_addr_i = 32'h4018;
    stat_write(6'h26);
    check_val("R7 status write", {26'd0, stat_o}, 32'h26);
    step_pkt(0, 0, 0, 0, 32'h4018, 0, 6'h26, 0, "R2 before break");
    step_pkt(0, 0, 1, 0, 32'hFFFF_F128, 0, 6'h28, 1, "R8 R10 break with masked irq");
    check_val("R8 debug pc", dpc_o, 32'h4020);
    check_val("R8 debug stat", {26'd0, dstat_o}, 32'h36);

    step_pkt(0, 0, 1, 0, 32'hFFFF_F130, 0, 6'h28, 1, "R10 second request held");
    step_pkt(0, 0, 0, 0, 32'hFFFF_F138, 0, 6'h28, 1, "R10 retry masked");

    stat_write(6'h22);
    step_pkt(0, 0, 0, 0, 32'hFFFF_F138, 0, 6'h00, 0, "R9 pending delivered");
    check_val("R9 backup pc", bpc_o, 32'hFFFF_F140);
    check_val("R9 backup stat", {26'd0, bstat_o}, 32'h22);

    stat_write(6'h02);
    step_pkt(0, 0, 0, 0, 32'hFFFF_F140, 0, 6'h02, 0, "R10 dropped request not delivered");
    step_pkt(0, 0, 1, 0, 32'hFFFF_F138, 0, 6'h00, 0, "R9 direct delivery");
    check_val("R9 backup pc direct", bpc_o, 32'hFFFF_F148);
    check_val("R9 backup stat direct", {26'd0, bstat_o}, 32'h02);

    step_pkt(0, 0, 1, 0, 32'hFFFF_F140, 0, 6'h00, 1, "R10 masked request pends");
    @(negedge clk);
    rst_ni = 1'b0;
    #2;
    check_val("R1 reset pc again", pc_o, 32'h1000);
    check_val("R1 reset pending", {31'd0, irq_pend_o}, 32'd0);
    check_val("R1 reset debug pc", dpc_o, 32'd0);
    check_val("R1 reset backup pc", bpc_o, 32'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule